// File: doc/BRIEF.md
# Card data FIFO packing engine

This block bridges a host-side FIFO of 32-bit words and a card data port that moves one byte per clock. When receiving from the card, it gathers incoming bytes into words, lowest byte first, and stores each word in the FIFO for the host to collect. When transmitting to the card, it takes words the host has stored and sends their bytes one at a time, also lowest byte first.

A start pulse loads a 16-bit byte length and latches the transfer direction. The engine counts the bytes still to move and reports them, both as bytes and as words rounded up. It raises end-of-data indications when the count reaches zero. It also drives FIFO level flags, and only the flags for the active direction are shown. The engine stops itself once no bytes remain and the FIFO has drained.

Top module: `card_fifo_packer`

## Requirements
- R1: After reset the engine is idle. `busy_o`, every flag, both end indications and both card strobes are 0, and `remaining_o` is 0.
- R2: A `start_i` pulse loads `len_i` into `remaining_o` at the next edge. `word_cnt_o` always equals (`remaining_o` + 3) >> 2.
- R3: In receive mode (`dir_rx_i`=1 at start), consecutive card bytes k0..k3 form the word {k3,k2,k1,k0}, so byte n sits in bits [8n+7:8n]. A word enters the FIFO after every fourth byte. The host reads words in arrival order.
- R4: If a receive transfer ends partway through a word, that word is still stored, and the lanes not filled are zero.
- R5: A card byte is accepted (`card_take_o`=1) only while receiving with bytes remaining, `card_rdy_i`=1 and fewer than 16 words held.
- R6: In transmit mode (`dir_rx_i`=0 at start), each stored word is sent as four bytes, bits [7:0] first, at one byte per cycle on `card_wr_o`/`card_wbyte_o`. Sending stalls while the FIFO is empty and no bytes of the current word remain. Bytes left in a word when the count reaches zero are dropped.
- R7: Every byte moved decrements `remaining_o` by one. Once a transfer has started and `remaining_o` is 0, `data_end_o` and `block_end_o` are 1.
- R8: When `remaining_o` is 0 and the FIFO is empty, `busy_o` drops and every receive and transmit flag reads 0.
- R9: While busy, the flags for the active direction follow the word count c: active=1, empty=(c==0), avail=(c>0), full=(c==16), half-empty (transmit)=(c<=8), half-full (receive)=(c>=8). The other direction's flags stay 0.
- R10: A store into a full FIFO is ignored. A host store while idle or receiving is ignored. A read of an empty FIFO returns 0 and changes nothing.
- R11: The direction is captured only by `start_i`. Changing `dir_rx_i` during a transfer has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse: load length, capture direction |
| dir_rx_i | input | 1 | Direction at start: 1 receive, 0 transmit |
| len_i | input | 16 | Transfer length in bytes |
| card_rdy_i | input | 1 | Card has a byte available |
| card_byte_i | input | 8 | Byte from the card |
| card_take_o | output | 1 | Byte from card consumed this cycle |
| card_wr_o | output | 1 | Byte to card valid this cycle |
| card_wbyte_o | output | 8 | Byte to the card |
| host_push_i | input | 1 | Host stores a word (transmit) |
| host_wdata_i | input | 32 | Word stored by the host |
| host_pop_i | input | 1 | Host takes a word (receive) |
| host_rdata_o | output | 32 | Oldest word, 0 when empty |
| busy_o | output | 1 | Engine enabled |
| remaining_o | output | 16 | Bytes still to move |
| word_cnt_o | output | 15 | Remaining words, rounded up |
| data_end_o | output | 1 | Byte count exhausted |
| block_end_o | output | 1 | Block complete |
| rx_act_o | output | 1 | Receive active |
| rx_empty_o | output | 1 | Receive FIFO empty |
| rx_avail_o | output | 1 | Receive data available |
| rx_full_o | output | 1 | Receive FIFO full |
| rx_half_full_o | output | 1 | Receive FIFO at least half full |
| tx_act_o | output | 1 | Transmit active |
| tx_empty_o | output | 1 | Transmit FIFO empty |
| tx_avail_o | output | 1 | Transmit data available |
| tx_full_o | output | 1 | Transmit FIFO full |
| tx_half_empty_o | output | 1 | Transmit FIFO at most half full |

## Verification
The bench fills the receive FIFO to 16 words against a card that is always ready. A design that missed the full stall would drop or overwrite words, and the popped stream would not match. Odd lengths end receive transfers mid-word: stale upper lanes would show up as nonzero padding, and a missing final push would leave the engine busy. On the transmit side the bench stores words faster than they drain, so wrap-around or overwrite faults appear as wrong bytes. It also lets a transfer end with bytes left in a word, which exposes an engine that hangs or sends too many bytes. A changed direction input mid-transfer and pops on an empty FIFO would corrupt order or data if the design honored them.

// File: rtl/cfp_pkg.sv
package cfp_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic active;
    logic empty;
    logic avail;
    logic full;
    logic le_half;
    logic ge_half;
  } lvl_flags_t;
endpackage

// File: rtl/cfp_word_fifo.sv
module cfp_word_fifo #(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              pop_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  count_nxt_o
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rd_ptr_q, rd_ptr_d, wr_ptr;
  logic [CNT_W-1:0]  count_q, count_d;
  logic              push_ok, pop_ok, ptr_en, cnt_en;

  always_comb begin
    push_ok  = push_i && (count_q != CNT_W'(DEPTH));
    pop_ok   = pop_i && (count_q != '0);
    wr_ptr   = rd_ptr_q + count_q[PTR_W-1:0];
    rd_ptr_d = rd_ptr_q + PTR_W'(1);
    count_d  = count_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
    ptr_en   = pop_ok;
    cnt_en   = push_ok || pop_ok;
    rdata_o  = (count_q != '0) ? mem[rd_ptr_q] : '0;
    count_o     = count_q;
    count_nxt_o = count_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (ptr_en) rd_ptr_q <= rd_ptr_d;
      if (cnt_en) count_q  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata_i;
  end

  assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));
  assert_full_push_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == CNT_W'(DEPTH) && push_i && !pop_i) |=> count_q == CNT_W'(DEPTH));
  assert_empty_pop_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == '0 && pop_i && !push_i) |=> (count_q == '0 && $stable(rd_ptr_q)));
endmodule

// File: rtl/cfp_rx_packer.sv
module cfp_rx_packer #(
  parameter int WORD_W = 32,
  localparam int LANES  = WORD_W / cfp_pkg::BYTE_W,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear_i,
  input  logic                       take_i,
  input  logic                       last_i,
  input  logic [cfp_pkg::BYTE_W-1:0] byte_i,
  output logic                       push_o,
  output logic [WORD_W-1:0]          word_o
);
  logic [LANE_W-1:0] lane_q, lane_d;
  logic [WORD_W-1:0] acc_q, acc_d;
  logic              en;

  always_comb begin
    word_o = acc_q | (WORD_W'(byte_i) << {lane_q, 3'b000});
    push_o = take_i && ((lane_q == LANE_W'(LANES - 1)) || last_i);
    en     = clear_i || take_i;
    lane_d = lane_q;
    acc_d  = acc_q;
    if (clear_i || push_o) begin
      lane_d = '0;
      acc_d  = '0;
    end else if (take_i) begin
      lane_d = lane_q + LANE_W'(1);
      acc_d  = word_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q <= '0;
      acc_q  <= '0;
    end else if (en) begin
      lane_q <= lane_d;
      acc_q  <= acc_d;
    end
  end

  // Lanes at or above the fill position must still be zero (partial word padding).
  assert_acc_upper_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q >> {lane_q, 3'b000}) == '0);
endmodule

// File: rtl/cfp_tx_unpacker.sv
module cfp_tx_unpacker #(
  parameter int WORD_W = 32,
  localparam int LANES  = WORD_W / cfp_pkg::BYTE_W,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear_i,
  input  logic                       run_i,
  input  logic [WORD_W-1:0]          head_i,
  input  logic                       empty_i,
  output logic                       send_o,
  output logic                       pop_o,
  output logic [cfp_pkg::BYTE_W-1:0] byte_o
);
  logic [LANE_W-1:0] left_q, left_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              en;

  always_comb begin
    pop_o  = run_i && (left_q == '0) && !empty_i;
    send_o = run_i && ((left_q != '0) || !empty_i);
    byte_o = (left_q != '0) ? sh_q[cfp_pkg::BYTE_W-1:0] : head_i[cfp_pkg::BYTE_W-1:0];
    en     = clear_i || send_o;
    left_d = left_q;
    sh_d   = sh_q;
    if (clear_i) begin
      left_d = '0;
      sh_d   = '0;
    end else if (pop_o) begin
      left_d = LANE_W'(LANES - 1);
      sh_d   = head_i >> cfp_pkg::BYTE_W;
    end else if (send_o) begin
      left_d = left_q - LANE_W'(1);
      sh_d   = sh_q >> cfp_pkg::BYTE_W;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      sh_q   <= '0;
    end else if (en) begin
      left_q <= left_d;
      sh_q   <= sh_d;
    end
  end

  assert_pop_refills_lanes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_o && !clear_i) |=> left_q == LANE_W'(LANES - 1));
endmodule

// File: rtl/cfp_flags.sv
module cfp_flags #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic                busy_i,
  input  logic                dir_rx_i,
  input  logic [CNT_W-1:0]    count_i,
  output cfp_pkg::lvl_flags_t rx_o,
  output cfp_pkg::lvl_flags_t tx_o
);
  cfp_pkg::lvl_flags_t lvl;

  always_comb begin
    lvl.active  = 1'b1;
    lvl.empty   = (count_i == '0);
    lvl.avail   = (count_i != '0);
    lvl.full    = (count_i == CNT_W'(DEPTH));
    lvl.le_half = (count_i <= CNT_W'(DEPTH / 2));
    lvl.ge_half = (count_i >= CNT_W'(DEPTH / 2));
    rx_o = (busy_i && dir_rx_i)  ? lvl : '0;
    tx_o = (busy_i && !dir_rx_i) ? lvl : '0;
  end
endmodule

// File: rtl/card_fifo_packer.sv
module card_fifo_packer #(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 32,
  parameter int LEN_W  = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1,
  localparam int BW    = cfp_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              dir_rx_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              card_rdy_i,
  input  logic [BW-1:0]     card_byte_i,
  output logic              card_take_o,
  output logic              card_wr_o,
  output logic [BW-1:0]     card_wbyte_o,
  input  logic              host_push_i,
  input  logic [WORD_W-1:0] host_wdata_i,
  input  logic              host_pop_i,
  output logic [WORD_W-1:0] host_rdata_o,
  output logic              busy_o,
  output logic [LEN_W-1:0]  remaining_o,
  output logic [LEN_W-2:0]  word_cnt_o,
  output logic              data_end_o,
  output logic              block_end_o,
  output logic              rx_act_o,
  output logic              rx_empty_o,
  output logic              rx_avail_o,
  output logic              rx_full_o,
  output logic              rx_half_full_o,
  output logic              tx_act_o,
  output logic              tx_empty_o,
  output logic              tx_avail_o,
  output logic              tx_full_o,
  output logic              tx_half_empty_o
);
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic              busy_q, busy_d, dir_q, armed_q;
  logic              rem_en, rem_nz, rx_run, tx_run, last_byte;
  logic              f_push, f_pop, f_full, f_empty;
  logic [WORD_W-1:0] f_wdata, f_rdata;
  logic [CNT_W-1:0]  f_count, f_count_nxt;
  logic              pk_push, up_send, up_pop;
  logic [WORD_W-1:0] pk_word;
  logic [LEN_W:0]    wc_sum;
  cfp_pkg::lvl_flags_t rx_fl, tx_fl;

  always_comb begin
    rem_nz    = (rem_q != '0);
    last_byte = (rem_q == LEN_W'(1));
    rx_run    = busy_q && dir_q && rem_nz;
    tx_run    = busy_q && !dir_q && rem_nz;
    f_full    = (f_count == CNT_W'(DEPTH));
    f_empty   = (f_count == '0);
    card_take_o = rx_run && card_rdy_i && !f_full;
    card_wr_o   = up_send;
    f_push  = dir_q ? pk_push : (host_push_i && busy_q);
    f_pop   = dir_q ? host_pop_i : up_pop;
    f_wdata = dir_q ? pk_word : host_wdata_i;
    rem_en  = start_i || card_take_o || card_wr_o;
    rem_d   = start_i ? len_i : (rem_en ? rem_q - LEN_W'(1) : rem_q);
    busy_d  = (start_i || busy_q) && !((rem_d == '0) && (f_count_nxt == '0));
    wc_sum  = {1'b0, rem_q} + (LEN_W + 1)'(3);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q   <= '0;
      busy_q  <= 1'b0;
      dir_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      if (rem_en)  rem_q   <= rem_d;
      if (start_i) dir_q   <= dir_rx_i;
      if (start_i) armed_q <= 1'b1;
    end
  end

  cfp_word_fifo #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_i(f_push), .wdata_i(f_wdata), .pop_i(f_pop),
    .rdata_o(f_rdata), .count_o(f_count), .count_nxt_o(f_count_nxt)
  );

  cfp_rx_packer #(.WORD_W(WORD_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .clear_i(start_i), .take_i(card_take_o),
    .last_i(last_byte), .byte_i(card_byte_i), .push_o(pk_push), .word_o(pk_word)
  );

  cfp_tx_unpacker #(.WORD_W(WORD_W)) u_unpack (
    .clk(clk), .rst_n(rst_n), .clear_i(start_i), .run_i(tx_run), .head_i(f_rdata),
    .empty_i(f_empty), .send_o(up_send), .pop_o(up_pop), .byte_o(card_wbyte_o)
  );

  cfp_flags #(.DEPTH(DEPTH)) u_flags (
    .busy_i(busy_q), .dir_rx_i(dir_q), .count_i(f_count), .rx_o(rx_fl), .tx_o(tx_fl)
  );

  always_comb begin
    host_rdata_o    = f_rdata;
    busy_o          = busy_q;
    remaining_o     = rem_q;
    word_cnt_o      = wc_sum[LEN_W:2];
    data_end_o      = armed_q && !rem_nz;
    block_end_o     = armed_q && !rem_nz;
    rx_act_o        = rx_fl.active;
    rx_empty_o      = rx_fl.empty;
    rx_avail_o      = rx_fl.avail;
    rx_full_o       = rx_fl.full;
    rx_half_full_o  = rx_fl.ge_half;
    tx_act_o        = tx_fl.active;
    tx_empty_o      = tx_fl.empty;
    tx_avail_o      = tx_fl.avail;
    tx_full_o       = tx_fl.full;
    tx_half_empty_o = tx_fl.le_half;
  end

  assert_take_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    card_take_o |-> (card_rdy_i && rx_act_o && !rx_full_o && remaining_o != '0));
  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((card_take_o || card_wr_o) && !start_i) |=> remaining_o == $past(remaining_o) - LEN_W'(1));
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!card_take_o && !card_wr_o && !rx_act_o && !tx_act_o));
  assert_one_direction_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_act_o, tx_act_o}));
  assert_dir_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !start_i) |=> $stable(dir_q));
endmodule

// File: tb/card_fifo_packer_tb.sv
module card_fifo_packer_tb;
  logic        clk, rst_n;
  logic        start_i, dir_rx_i, card_rdy_i, host_push_i, host_pop_i;
  logic [15:0] len_i;
  logic [7:0]  card_byte_i;
  logic [31:0] host_wdata_i;
  logic        card_take_o, card_wr_o, busy_o, data_end_o, block_end_o;
  logic [7:0]  card_wbyte_o;
  logic [31:0] host_rdata_o;
  logic [15:0] remaining_o;
  logic [14:0] word_cnt_o;
  logic rx_act_o, rx_empty_o, rx_avail_o, rx_full_o, rx_half_full_o;
  logic tx_act_o, tx_empty_o, tx_avail_o, tx_full_o, tx_half_empty_o;

  int nchk = 0, nerr = 0;
  int rb, rxw, txi, cur_len, seed;
  bit cur_rx, seen_full;
  logic [31:0] wq[$];

  card_fifo_packer u_dut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL R8 watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] gen(int i);
    return 8'((i + seed) * 37 + 11);
  endfunction

  function automatic logic [31:0] exp_word(int k);
    logic [31:0] w = '0;
    for (int j = 0; j < 4; j++)
      if (4 * k + j < cur_len) w[8*j +: 8] = gen(4 * k + j);
    return w;
  endfunction

  task automatic cyc();
    card_byte_i = gen(rb);
    #1;
    if (card_take_o) rb++;
    if (card_wr_o) begin
      logic [31:0] w = (txi / 4 < wq.size()) ? wq[txi / 4] : 32'hx;
      chk("R6 tx byte", {24'd0, card_wbyte_o}, {24'd0, w[8*(txi%4) +: 8]});
      txi++;
    end
    if (host_pop_i && rx_avail_o) begin
      chk((4 * rxw + 4 > cur_len) ? "R4 partial word" : "R3 rx word", host_rdata_o, exp_word(rxw));
      rxw++;
    end
    if (host_push_i && tx_act_o && !tx_full_o) wq.push_back(host_wdata_i);
    if (tx_full_o) seen_full = 1'b1;
    @(negedge clk);
    start_i = 1'b0; host_push_i = 1'b0; host_pop_i = 1'b0;
  endtask

  task automatic start_xfer(bit rx, int len, int s);
    cur_rx = rx; cur_len = len; seed = s;
    rb = 0; rxw = 0; txi = 0; seen_full = 1'b0;
    wq.delete();
    dir_rx_i = rx; len_i = 16'(len); start_i = 1'b1;
    cyc();
    chk("R2 length loaded", {16'd0, remaining_o}, len);
    chk("R2 word count", {17'd0, word_cnt_o}, (len + 3) >> 2);
  endtask

  task automatic run_until_idle(int p_rdy, int p_host);
    int n = 0;
    while (busy_o && n < 4000) begin
      card_rdy_i = ($urandom % 100) < p_rdy;
      if (cur_rx) host_pop_i = ($urandom % 100) < p_host;
      else if (wq.size() * 4 < cur_len) begin
        host_push_i  = ($urandom % 100) < p_host;
        host_wdata_i = $urandom;
      end
      cyc();
      n++;
    end
    card_rdy_i = 1'b0;
  endtask

  task automatic end_checks();
    chk("R8 engine stopped", {31'd0, busy_o}, 0);
    chk("R7 data end", {30'd0, data_end_o, block_end_o}, 32'h3);
    chk("R8 flags cleared", {22'd0, rx_act_o, rx_empty_o, rx_avail_o, rx_full_o, rx_half_full_o,
        tx_act_o, tx_empty_o, tx_avail_o, tx_full_o, tx_half_empty_o}, 0);
    chk("R2 word count at end", {17'd0, word_cnt_o}, 0);
    if (cur_rx) chk("R3 words received", rxw, (cur_len + 3) / 4);
    else        chk("R6 bytes sent", txi, cur_len);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start_i = 0; dir_rx_i = 0; len_i = 0; card_rdy_i = 0;
    card_byte_i = 0; host_push_i = 0; host_wdata_i = 0; host_pop_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 idle", {24'd0, busy_o, card_take_o, card_wr_o, data_end_o, block_end_o, 3'd0}, 0);
    chk("R1 remaining", {16'd0, remaining_o}, 0);
    chk("R1 flags", {22'd0, rx_act_o, rx_empty_o, rx_avail_o, rx_full_o, rx_half_full_o,
        tx_act_o, tx_empty_o, tx_avail_o, tx_full_o, tx_half_empty_o}, 0);

    // Receive 80 bytes with no host reads: FIFO fills, engine stalls (R5, R9)
    start_xfer(1'b1, 80, 3);
    chk("R7 no end while running", {31'd0, data_end_o}, 0);
    card_rdy_i = 1'b1;
    repeat (90) cyc();
    chk("R5 stall on full", {31'd0, card_take_o}, 0);
    chk("R7 remaining after fill", {16'd0, remaining_o}, 16);
    chk("R2 word count after fill", {17'd0, word_cnt_o}, 4);
    chk("R9 rx flags full", {27'd0, rx_act_o, rx_empty_o, rx_avail_o, rx_full_o, rx_half_full_o}, 32'b10111);
    chk("R9 tx flags hidden", {27'd0, tx_act_o, tx_empty_o, tx_avail_o, tx_full_o, tx_half_empty_o}, 0);
    card_rdy_i = 1'b0; host_pop_i = 1'b1;
    cyc();
    chk("R5 stall when card not ready", {31'd0, card_take_o}, 0);
    chk("R9 rx flags at 15", {27'd0, rx_act_o, rx_empty_o, rx_avail_o, rx_full_o, rx_half_full_o}, 32'b10101);
    run_until_idle(100, 50);
    end_checks();

    // Odd length ends mid-word (R4)
    start_xfer(1'b1, 6, 9);
    run_until_idle(100, 30);
    end_checks();

    // Pop of an empty FIFO (R10)
    start_xfer(1'b1, 8, 21);
    card_rdy_i = 1'b0; host_pop_i = 1'b1;
    #1 chk("R10 empty read returns zero", host_rdata_o, 0);
    cyc();
    chk("R10 empty read no change", {30'd0, rx_empty_o, rx_avail_o}, 32'b10);
    run_until_idle(100, 50);
    end_checks();

    // Transmit with an empty FIFO stalls, direction input change ignored (R6, R9, R11)
    start_xfer(1'b0, 10, 0);
    repeat (3) cyc();
    chk("R6 stall while empty", {31'd0, card_wr_o}, 0);
    chk("R9 tx flags empty", {27'd0, tx_act_o, tx_empty_o, tx_avail_o, tx_full_o, tx_half_empty_o}, 32'b11001);
    chk("R9 rx flags hidden", {27'd0, rx_act_o, rx_empty_o, rx_avail_o, rx_full_o, rx_half_full_o}, 0);
    dir_rx_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      host_push_i = 1'b1; host_wdata_i = 32'hA1B2C3D4 + 32'(i) * 32'h01010101;
      cyc();
    end
    chk("R11 direction held", {30'd0, tx_act_o, rx_act_o}, 32'b10);
    run_until_idle(100, 0);
    end_checks();
    dir_rx_i = 1'b0;

    // Host store while idle is ignored (R10)
    host_push_i = 1'b1; host_wdata_i = 32'hDEADBEEF;
    cyc();
    start_xfer(1'b0, 4, 0);
    chk("R10 idle store ignored", {31'd0, tx_empty_o}, 1);
    run_until_idle(100, 100);
    end_checks();

    // Stores faster than the drain: FIFO fills, extra stores dropped (R9, R10)
    start_xfer(1'b0, 160, 0);
    for (int i = 0; i < 40; i++) begin
      host_push_i = 1'b1; host_wdata_i = $urandom;
      cyc();
    end
    chk("R9 tx full seen", {31'd0, seen_full}, 1);
    chk("R10 stores to full dropped", {31'd0, wq.size() < 40}, 1);
    run_until_idle(100, 100);
    end_checks();

    // Constrained random transfers
    for (int it = 0; it < 12; it++) begin
      start_xfer(1'($urandom % 2), 1 + int'($urandom % 48), it * 13);
      run_until_idle(60, 50);
      end_checks();
    end

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule